// File: doc/BRIEF.md
# Power-Management Event Wake Message Bridge

This block collects power-management event notifications from a group of downstream link ports. It keeps one sticky status bit for each port. From those bits it produces a single shared wake level toward an upstream I/O hub. That level is carried as a stream of two message kinds: "raise" (assert) and "lower" (deassert). The upstream level acts as a wired-OR of every source: it rises when the first source becomes pending and falls only when the last pending source has been cleared by software.

Software clears a port's status bit by pulsing that port's write-one-to-clear strobe. A resume-from-deep-sleep indication, taken only while reset is released, forces a raise message so that the wake is reported even when no port bit is set. Once that raise has been accepted upstream, the level again follows the status bits alone.

The message interface is valid/ready. A message is transferred on a cycle where `msg_valid_o` and `msg_ready_i` are both high. While valid is high and ready is low, a raise request stays valid with unchanged kind until it is accepted. A pending lower request is the single exception: it may be withdrawn before acceptance when a port becomes pending again, because a lower followed by a raise would tell the hub something already stale. `msg_ready_i` is ignored while valid is low.

Top module: `pme_gpe_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, all status bits, `msg_valid_o` and `gpe_level_o` are 0 after that edge, and a resume indication seen during reset has no later effect.
- R2: A pulse on `pme_msg_i[i]` sets `status_o[i]` from the next cycle on.
- R3: A pulse on `status_clr_i[i]` clears `status_o[i]` in the next cycle. A set pulse and a clear pulse on the same port in the same cycle leave the bit set. A clear of a bit that is already 0 changes nothing.
- R4: When a status bit becomes set while `gpe_level_o` is 0 and no message is waiting, a raise request (`msg_kind_o` = 0) is valid in the cycle after the event pulse.
- R5: A raise request stays valid with the same kind until accepted. Each accepted message updates `gpe_level_o` in the next cycle: 1 after a raise, 0 after a lower.
- R6: A lower request (`msg_kind_o` = 1) is produced only when all status bits are 0 and `gpe_level_o` is 1. Clearing one port while another is still set produces no message.
- R7: After reset, accepted messages strictly alternate, starting with a raise.
- R8: If any port becomes pending while a lower request waits unaccepted, the request is withdrawn in the next cycle, no message is sent and `gpe_level_o` stays 1. If the lower is accepted in the same cycle as the new event, a raise request follows in the next cycle.
- R9: A resume pulse with `rst` low and `gpe_level_o` 0 produces a raise request in the next cycle. Once that raise is accepted and no status bit is set, a lower request follows. A resume pulse while the level is already 1 produces no message.
- R10: A raise request is never withdrawn, even if all status bits are cleared before acceptance. The matching lower request is issued in the cycle after the raise is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pme_msg_i | input | NUM_PORTS | One-cycle pulse per received event notification, one bit per port |
| status_clr_i | input | NUM_PORTS | Write-one-to-clear strobe for each port's status bit |
| s3_exit_i | input | 1 | Pulse marking resume from deep sleep after reset release |
| msg_ready_i | input | 1 | Upstream sender accepts the current message |
| msg_valid_o | output | 1 | A message request is waiting |
| msg_kind_o | output | 1 | 0 = raise (assert), 1 = lower (deassert) |
| status_o | output | NUM_PORTS | Per-port sticky event status |
| gpe_level_o | output | 1 | Level last accepted by the upstream sender |

## Verification
A wrong status bit shows on `status_o` one cycle after the pulse. If the shared level tracker gets out of step with the bits, the next handshake carries the wrong kind, or a raise or lower goes missing entirely. The bench catches that at the very next acceptance by comparing against its own model of the OR level. Withdrawal and hold faults show as `msg_valid_o` dropping or persisting one cycle after a stalled request, so the stall-and-event corner cases are driven with `msg_ready_i` low.

// File: rtl/pme_gpe_pkg.sv
package pme_gpe_pkg;
  typedef enum logic {
    MSG_ASSERT   = 1'b0,
    MSG_DEASSERT = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/pme_status_bank.sv
// Per-port sticky status bits with write-one-to-clear; set wins over clear.
module pme_status_bank #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] set_i,
  input  logic [NUM_PORTS-1:0] clr_i,
  output logic [NUM_PORTS-1:0] status_q,
  output logic                 any_next_o
);
  logic [NUM_PORTS-1:0] status_d;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign status_d[p] = set_i[p] | (status_q[p] & ~clr_i[p]);
    always_ff @(posedge clk) begin
      if (rst) status_q[p] <= 1'b0;
      else     status_q[p] <= status_d[p];
    end
  end

  assign any_next_o = (!rst) && (|status_d);
endmodule

// File: rtl/pme_msg_sequencer.sv
// Turns the wanted OR level into alternating raise/lower requests on a
// valid/ready interface; a waiting lower is withdrawn if the level is wanted again.
module pme_msg_sequencer
  import pme_gpe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      any_next_i,
  input  logic      s3_exit_i,
  input  logic      ready_i,
  output logic      valid_o,
  output msg_kind_e kind_o,
  output logic      level_o
);
  logic      pend_q, pend_n;
  msg_kind_e kind_q, kind_n;
  logic      up_q, up_n;
  logic      wake_q, wake_n;
  logic      fire, want;

  always_comb begin
    fire   = pend_q & ready_i;
    up_n   = fire ? (kind_q == MSG_ASSERT) : up_q;
    wake_n = (wake_q | s3_exit_i) & ~up_n;
    want   = any_next_i | wake_n;
    pend_n = pend_q & ~fire;
    kind_n = kind_q;
    if (pend_n && (kind_q == MSG_DEASSERT) && want) pend_n = 1'b0;
    if (!pend_n && (want != up_n)) begin
      pend_n = 1'b1;
      kind_n = want ? MSG_ASSERT : MSG_DEASSERT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      kind_q <= MSG_ASSERT;
      up_q   <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      kind_q <= kind_n;
      up_q   <= up_n;
      wake_q <= wake_n;
    end
  end

  assign valid_o = pend_q;
  assign kind_o  = kind_q;
  assign level_o = up_q;
endmodule

// File: rtl/pme_gpe_bridge.sv
module pme_gpe_bridge
  import pme_gpe_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] pme_msg_i,
  input  logic [NUM_PORTS-1:0] status_clr_i,
  input  logic                 s3_exit_i,
  input  logic                 msg_ready_i,
  output logic                 msg_valid_o,
  output logic                 msg_kind_o,
  output logic [NUM_PORTS-1:0] status_o,
  output logic                 gpe_level_o
);
  logic      any_next;
  msg_kind_e kind;

  pme_status_bank #(.NUM_PORTS(NUM_PORTS)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set_i      (pme_msg_i),
    .clr_i      (status_clr_i),
    .status_q   (status_o),
    .any_next_o (any_next)
  );

  pme_msg_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .any_next_i (any_next),
    .s3_exit_i  (s3_exit_i),
    .ready_i    (msg_ready_i),
    .valid_o    (msg_valid_o),
    .kind_o     (kind),
    .level_o    (gpe_level_o)
  );

  assign msg_kind_o = kind;
endmodule

// File: rtl/pme_gpe_bridge_chk.sv
module pme_gpe_bridge_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_PORTS-1:0] pme_msg_i,
  input logic [NUM_PORTS-1:0] status_clr_i,
  input logic                 s3_exit_i,
  input logic                 msg_ready_i,
  input logic                 msg_valid_o,
  input logic                 msg_kind_o,
  input logic [NUM_PORTS-1:0] status_o,
  input logic                 gpe_level_o
);
  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (status_o == '0) && !msg_valid_o && !gpe_level_o);

  // R2
  p_status_set_r2: assert property (@(posedge clk) disable iff (rst)
    (|pme_msg_i) |=> ((status_o & $past(pme_msg_i)) == $past(pme_msg_i)));

  // R5
  p_raise_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && !msg_ready_i && !msg_kind_o) |=> (msg_valid_o && !msg_kind_o));

  // R5
  p_level_follows_r5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && msg_ready_i) |=> (gpe_level_o == !$past(msg_kind_o)));

  // R6
  p_lower_only_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && msg_kind_o) |-> (status_o == '0) && gpe_level_o);

  // R7
  p_alternate_r7: assert property (@(posedge clk) disable iff (rst)
    msg_valid_o |-> (msg_kind_o == gpe_level_o));

  // R8
  p_lower_withdraw_r8: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && !msg_ready_i && msg_kind_o) |=>
      ((msg_valid_o && msg_kind_o) || (status_o != '0)));
endmodule

bind pme_gpe_bridge pme_gpe_bridge_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pme_msg_i    (pme_msg_i),
  .status_clr_i (status_clr_i),
  .s3_exit_i    (s3_exit_i),
  .msg_ready_i  (msg_ready_i),
  .msg_valid_o  (msg_valid_o),
  .msg_kind_o   (msg_kind_o),
  .status_o     (status_o),
  .gpe_level_o  (gpe_level_o)
);

// File: tb/pme_gpe_bridge_bench.sv
module pme_gpe_bridge_bench;
  localparam int NP = 4;
  localparam int NV = 26;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pme = '0;
  logic [NP-1:0] clr = '0;
  logic          s3  = 1'b0;
  logic          rdy = 1'b0;
  logic          valid, kind, level;
  logic [NP-1:0] status;

  int checks = 0;
  int fails  = 0;
  logic model_lvl = 1'b0;

  always #4 clk = ~clk;

  pme_gpe_bridge #(.NUM_PORTS(NP)) u_pme_gpe_bridge (
    .clk(clk), .rst(rst), .pme_msg_i(pme), .status_clr_i(clr),
    .s3_exit_i(s3), .msg_ready_i(rdy), .msg_valid_o(valid),
    .msg_kind_o(kind), .status_o(status), .gpe_level_o(level)
  );

  // {pme, clr, s3, rdy, exp_valid, exp_kind, exp_status, exp_level}
  localparam logic [16:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b0}, // 0  R2 R4 raise
    {4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b0}, // 1  R5 held
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0001, 1'b1}, // 2  R5 accepted
    {4'b0010, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0011, 1'b1}, // 3  R2 second port
    {4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b1}, // 4  R6 partial clear
    {4'b0010, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b1}, // 5  R3 set wins
    {4'b0000, 4'b0010, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b1}, // 6  R6 lower
    {4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b1}, // 7  lower waits
    {4'b0100, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100, 1'b1}, // 8  R8 withdrawn
    {4'b0000, 4'b0100, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b1}, // 9  R6 lower again
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0}, // 10 R5 lower accepted
    {4'b1000, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1000, 1'b0}, // 11 R4 raise
    {4'b0000, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0}, // 12 R10 raise kept
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b1}, // 13 R10 lower follows
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0}, // 14 R7
    {4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0}, // 15 R9 resume raise
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b1}, // 16 R9 lower follows
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0}, // 17 R9
    {4'b0001, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0001, 1'b0}, // 18 R4 ready idle
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0001, 1'b1}, // 19 R5
    {4'b0000, 4'b0001, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b1}, // 20 R6
    {4'b0010, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0010, 1'b0}, // 21 R8 accept + event
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0010, 1'b1}, // 22 R7
    {4'b0000, 4'b0010, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b1}, // 23 R6
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0}, // 24 R5
    {4'b0000, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0}  // 25 R3 clear of zeros
  };

  task automatic check(input string req, input logic ev, input logic ek,
                       input logic [NP-1:0] es, input logic el);
    checks++;
    if (valid !== ev || (ev && kind !== ek) || status !== es || level !== el) begin
      fails++;
      $display("FAIL %s: valid=%b kind=%b status=%b level=%b expected valid=%b kind=%b status=%b level=%b",
               req, valid, kind, status, level, ev, ek, es, el);
    end
  endtask

  task automatic step(input logic [NP-1:0] p, input logic [NP-1:0] c,
                      input logic s, input logic r);
    @(negedge clk);
    pme = p; clr = c; s3 = s; rdy = r;
    @(posedge clk);
    #2;
    pme = '0; clr = '0; s3 = 1'b0;
  endtask

  // Handshake monitor, sampled just before each rising edge: R7 alternation.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst) model_lvl = 1'b0;
      else if (valid && rdy) begin
        checks++;
        if (kind !== model_lvl) begin
          fails++;
          $display("FAIL R7: accepted kind=%b expected=%b", kind, model_lvl);
        end
        model_lvl = ~model_lvl;
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 1'b0, 1'b0, '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16:13], VEC[i][12:9], VEC[i][8], VEC[i][7]);
      check($sformatf("vector %0d", i), VEC[i][6], VEC[i][5], VEC[i][4:1], VEC[i][0]);
    end

    // R1: reset in the middle of a pending raise, resume during reset ignored
    step(4'b0101, 4'b0000, 1'b0, 1'b0);
    check("R4", 1'b1, 1'b0, 4'b0101, 1'b0);
    @(negedge clk);
    rst = 1'b1; s3 = 1'b1;
    @(posedge clk);
    #2;
    check("R1", 1'b0, 1'b0, '0, 1'b0);
    @(negedge clk);
    rst = 1'b0; s3 = 1'b0;
    step(4'b0000, 4'b0000, 1'b0, 1'b1);
    check("R1 resume in reset", 1'b0, 1'b0, '0, 1'b0);

    // R9: resume while level is already high sends nothing
    step(4'b0001, 4'b0000, 1'b0, 1'b1);
    step(4'b0000, 4'b0000, 1'b0, 1'b1);
    check("R9 setup", 1'b0, 1'b0, 4'b0001, 1'b1);
    step(4'b0000, 4'b0000, 1'b1, 1'b1);
    check("R9 no duplicate", 1'b0, 1'b0, 4'b0001, 1'b1);
    step(4'b0000, 4'b0001, 1'b0, 1'b0);
    check("R6", 1'b1, 1'b1, 4'b0000, 1'b1);
    step(4'b0000, 4'b0000, 1'b0, 1'b1);
    check("R5", 1'b0, 1'b0, 4'b0000, 1'b0);

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule